// File: doc/BRIEF.md
# Prescaled Signed Charge Accumulator

This block is the digital back end of a battery charge counter. A current-sense converter delivers signed conversion results as a one-cycle strobe plus a signed delta. The block corrects each delta for a programmed offset, can add a ±1 dither, and sums the result into a wide signed residue. Each time the residue reaches plus or minus a programmable 15-bit scale value, a 16-bit two's-complement result counter moves by one in that direction. This lets one result LSB stand for a fixed amount of charge, for example one coulomb with a scale of 2621 on a 20 mΩ shunt. Net discharge shows as a negative count.

A host drives three write-only registers through a write strobe, a 2-bit address and a 16-bit data word. It reads the result counter and a 5-bit status word directly. Address 0 is the control word: bit 0 run, bit 1 clear request (self-clearing), bit 2 analog-calibration flag, bit 3 correction disable, bit 4 dither enable. Address 1 takes the scale in bits 14:0. Address 2 takes the signed offset word. The status word reads {dither, correction disable, calibration, clear busy, run} from bit 4 down to bit 0.

A clear request starts a timed clear period of `CLEAR_CYCLES` clocks. For the whole of that period, the counter, the residue and the dither generator are held cleared and converter strobes are dropped.

Top module: `charge_accum`

## Requirements
- R1: After reset `ccOut` is 0 and `ctrlStat` is 0. `ccOut` wraps modulo 2^16 without saturating: one step up from 0x7FFF gives 0x8000, and one step down from 0x0000 gives 0xFFFF.
- R2: While running, the residue takes each accepted corrected delta. When the residue reaches +scale or more, `ccOut` increments and scale is subtracted from the residue. When it reaches −scale or less, `ccOut` decrements and scale is added to the residue. `ccOut` moves by at most one per clock, in the clock edge that accepts the strobe.
- R3: A scale of 1 moves `ccOut` once per accumulated count, and a scale of 0 acts as 1. A residue that holds more than one scale keeps stepping `ccOut` by one on each following clock while running.
- R4: Writing address 0 with bit 1 set raises status bit 1 for exactly `CLEAR_CYCLES` clocks, after which the bit drops by itself. During that time `ccOut` and the residue are forced to 0.
- R5: Converter strobes that arrive while status bit 1 is high have no effect: `ccOut` is 0 after the clear period ends and stays 0.
- R6: With run (control bit 0) low, `ccOut` holds and strobes are ignored.
- R7: Stopping and restarting keeps the residue, the scale and `ccOut`, so counting resumes from where it stopped.
- R8: With correction enabled (control bit 3 low), the offset word is subtracted from each delta before accumulation.
- R9: With correction disabled (control bit 3 high), deltas are used unchanged and the dither request has no effect.
- R10: With dither requested (bit 4) and correction enabled, every accepted delta is changed by +1 or −1 from a 16-bit LFSR. With a scale of 1 and zero deltas, each sample therefore moves `ccOut` by exactly one.
- R11: The calibration flag (control bit 2) reads back in status bit 2 and stays set until the host writes it low. Accumulation continues while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 control, 1 scale, 2 offset) |
| wrData | input | 16 | Register write data |
| adcValid | input | 1 | Converter result strobe |
| adcDelta | input | 16 | Signed converter result |
| ccOut | output | 16 | Two's-complement result counter |
| ctrlStat | output | 5 | {dither, corrDisable, calibration, clearBusy, run} |

## Verification
The bench drives the counter across both wrap points. A saturating design would stick at 0x7FFF, and a sign error would show the wrong half of the range. It loads a large delta with a scale of 1 to check that the residue drains one step per clock: a design that lost the excess, or jumped by several steps at once, would end on the wrong count. It also feeds strobes during the clear period and while stopped, checks that a partial residue survives a stop but not a clear, and confirms that dither stays silent whenever correction is disabled.

// File: rtl/charge_accum_pkg.sv
package charge_accum_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_SCALE  = 2'd1,
    ADDR_OFFSET = 2'd2
  } ccAddr_e;

  localparam int BIT_RUN  = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_CAL  = 2;
  localparam int BIT_NCOR = 3;
  localparam int BIT_DITH = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // hold accumulation state at zero
    logic run;    // stepping allowed this cycle
    logic take;   // fold the current delta in
    logic corr;   // subtract the offset word
    logic dith;   // add the LFSR dither
  } ccStrobe_t;

endpackage

// File: rtl/charge_accum_ctrl.sv
module charge_accum_ctrl
  import charge_accum_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SCALE_W      = 15,
  parameter int CLEAR_CYCLES = 4000,
  parameter int SCALE_INIT   = 2621
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [1:0]               wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     adcValid,
  output ccStrobe_t                strobe,
  output logic [SCALE_W-1:0]       scale,
  output logic signed [DATA_W-1:0] offset,
  output logic [4:0]               ctrlStat
);

  localparam int TMR_W = $clog2(CLEAR_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(CLEAR_CYCLES - 1);

  logic             runBit, calBit, corrOff, dithBit, busy;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      calBit  <= 1'b0;
      corrOff <= 1'b0;
      dithBit <= 1'b0;
      busy    <= 1'b0;
      tmr     <= '0;
      scale   <= SCALE_W'(SCALE_INIT);
      offset  <= '0;
    end else begin
      if (busy) begin
        if (tmr == '0) busy <= 1'b0;
        else           tmr  <= tmr - 1'b1;
      end
      if (wrEn) begin
        case (ccAddr_e'(wrAddr))
          ADDR_CTRL: begin
            runBit  <= wrData[BIT_RUN];
            calBit  <= wrData[BIT_CAL];
            corrOff <= wrData[BIT_NCOR];
            dithBit <= wrData[BIT_DITH];
            if (wrData[BIT_CLR]) begin
              busy <= 1'b1;
              tmr  <= TMR_LOAD;
            end
          end
          ADDR_SCALE:  scale  <= wrData[SCALE_W-1:0];
          ADDR_OFFSET: offset <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.clear = busy;
    strobe.run   = runBit & ~busy;
    strobe.take  = adcValid & runBit & ~busy;
    strobe.corr  = ~corrOff;
    strobe.dith  = dithBit & ~corrOff;
  end

  assign ctrlStat = {dithBit, corrOff, calBit, busy, runBit};

endmodule

// File: rtl/charge_accum_lfsr.sv
module charge_accum_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         advance,
  output logic [W-1:0] state
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= SEED;
    else if (clear)   state <= SEED;
    else if (advance) state <= (state >> 1) ^ (state[0] ? TAPS : '0);
  end

endmodule

// File: rtl/charge_accum_datapath.sv
module charge_accum_datapath
  import charge_accum_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int SCALE_W = 15,
  parameter int RES_W   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ccStrobe_t                strobe,
  input  logic signed [DATA_W-1:0] adcDelta,
  input  logic [SCALE_W-1:0]       scale,
  input  logic signed [DATA_W-1:0] offset,
  output logic [CNT_W-1:0]         ccOut
);

  localparam int COR_W = DATA_W + 2;

  logic [15:0]              lfsr;
  logic [SCALE_W-1:0]       scaleNz;
  logic signed [RES_W-1:0]  effScale, residue, sum;
  logic signed [COR_W-1:0]  deltaX, offX, corrected, dithered;

  charge_accum_lfsr #(.W(16)) u_lfsr (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobe.clear),
    .advance (strobe.take & strobe.dith),
    .state   (lfsr)
  );

  always_comb begin
    scaleNz   = (scale == '0) ? SCALE_W'(1) : scale;
    effScale  = $signed({{(RES_W - SCALE_W){1'b0}}, scaleNz});
    deltaX    = {{2{adcDelta[DATA_W-1]}}, adcDelta};
    offX      = {{2{offset[DATA_W-1]}}, offset};
    corrected = strobe.corr ? (deltaX - offX) : deltaX;
    if (strobe.dith)
      dithered = lfsr[0] ? (corrected + COR_W'(1)) : (corrected - COR_W'(1));
    else
      dithered = corrected;
    sum = residue;
    if (strobe.take)
      sum = residue + $signed({{(RES_W - COR_W){dithered[COR_W-1]}}, dithered});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      residue <= '0;
      ccOut   <= '0;
    end else if (strobe.clear) begin
      residue <= '0;
      ccOut   <= '0;
    end else if (strobe.run) begin
      if (sum >= effScale) begin
        ccOut   <= ccOut + 1'b1;
        residue <= sum - effScale;
      end else if (sum <= -effScale) begin
        ccOut   <= ccOut - 1'b1;
        residue <= sum + effScale;
      end else begin
        residue <= sum;
      end
    end
  end

endmodule

// File: rtl/charge_accum.sv
module charge_accum
  import charge_accum_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 16,
  parameter int SCALE_W      = 15,
  parameter int RES_W        = 32,
  parameter int CLEAR_CYCLES = 4000,
  parameter int SCALE_INIT   = 2621
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcDelta,
  output logic [CNT_W-1:0]  ccOut,
  output logic [4:0]        ctrlStat
);

  ccStrobe_t                strobe;
  logic [SCALE_W-1:0]       scale;
  logic signed [DATA_W-1:0] offset;

  charge_accum_ctrl #(
    .DATA_W(DATA_W), .SCALE_W(SCALE_W),
    .CLEAR_CYCLES(CLEAR_CYCLES), .SCALE_INIT(SCALE_INIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .adcValid(adcValid), .strobe(strobe), .scale(scale), .offset(offset),
    .ctrlStat(ctrlStat)
  );

  charge_accum_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SCALE_W(SCALE_W), .RES_W(RES_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcDelta($signed(adcDelta)),
    .scale(scale), .offset(offset), .ccOut(ccOut)
  );

endmodule

// File: rtl/charge_accum_chk.sv
module charge_accum_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic             busy,
  input logic             runOn,
  input logic             calOn,
  input logic [CNT_W-1:0] ccOut
);

  logic             armed, lastBusy;
  logic [CNT_W-1:0] lastOut, upVal, dnVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      lastBusy <= 1'b0;
      lastOut  <= '0;
    end else begin
      armed    <= 1'b1;
      lastBusy <= busy;
      lastOut  <= ccOut;
    end
  end

  assign upVal = lastOut + 1'b1;
  assign dnVal = lastOut - 1'b1;

  // R2: one step at most per clock, wrapping modulo 2^16 (R1)
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !lastBusy) |-> (ccOut == lastOut || ccOut == upVal || ccOut == dnVal));

  // R4 / R5: counter is zero after every clear-busy cycle
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (ccOut == '0));

  // R6: stopped counter holds
  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!runOn && !busy) |=> $stable(ccOut));

  // R11: calibration flag changes only through a control write
  p_cal_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == 2'd0) |=> $stable(calOn));

endmodule

bind charge_accum charge_accum_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .busy(ctrlStat[1]), .runOn(ctrlStat[0]), .calOn(ctrlStat[2]), .ccOut(ccOut)
);

// File: tb/test_charge_accum.sv
module test_charge_accum;

  localparam int CLK_PERIOD = 10;
  localparam int CLR_N      = 12;
  localparam int NVEC       = 12;

  // scale 3, offset 0: delta and expected counter after each sample
  localparam logic [15:0] VEC_D [NVEC] = '{16'd1, 16'd1, 16'd1, 16'd2, 16'd2, 16'hFFFF,
                                           16'hFFFD, 16'hFFFE, 16'hFFFE, 16'd3, 16'hFFFD, 16'hFFFD};
  localparam logic [15:0] VEC_E [NVEC] = '{16'd0, 16'd0, 16'd1, 16'd1, 16'd2, 16'd2,
                                           16'd1, 16'd1, 16'd0, 16'd0, 16'd0, 16'hFFFF};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        adcValid = 1'b0;
  logic [15:0] adcDelta = '0;
  logic [15:0] ccOut;
  logic [4:0]  ctrlStat;

  int checks = 0;
  int fails  = 0;

  charge_accum #(.CLEAR_CYCLES(CLR_N)) i_charge_accum (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .adcValid(adcValid), .adcDelta(adcDelta), .ccOut(ccOut), .ctrlStat(ctrlStat)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sample(input logic [15:0] d);
    @(negedge clk);
    adcValid = 1'b1; adcDelta = d;
    @(negedge clk);
    adcValid = 1'b0;
  endtask

  task automatic clearAndRun(input logic [15:0] ctrlBits, output int busyLen);
    wr(2'd0, ctrlBits | 16'h0002);
    busyLen = 0;
    while (ctrlStat[1] && busyLen < 10 * CLR_N) begin
      busyLen++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int bl;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset ccOut", ccOut, 16'h0);
    check("R1 reset ctrlStat", ctrlStat, 5'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: vector table, scale 3
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0001);
    for (int i = 0; i < NVEC; i++) begin
      sample(VEC_D[i]);
      check("R2 table step", ccOut, VEC_E[i]);
    end

    // R4: clear period length and zeroing
    clearAndRun(16'h0001, bl);
    check("R4 busy length", bl, CLR_N);
    check("R4 cleared counter", ccOut, 16'h0);
    wr(2'd1, 16'd4);
    sample(16'd3);
    clearAndRun(16'h0001, bl);
    sample(16'd1);
    check("R4 residue cleared", ccOut, 16'h0);

    // R5: strobes during clear ignored
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h0003);
    sample(16'd100);
    while (ctrlStat[1]) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R5 busy strobe ignored", ccOut, 16'h0);

    // R3: scale 0 acts as 1; excess drains one per clock
    wr(2'd1, 16'd0);
    sample(16'd1);
    check("R3 scale zero as one", ccOut, 16'd1);
    sample(16'd5);
    check("R3 one step per clock", ccOut, 16'd2);
    repeat (6) @(negedge clk);
    check("R3 drained excess", ccOut, 16'd6);

    // R1: wrap both ways
    clearAndRun(16'h0001, bl);
    sample(16'hFFFF);
    check("R1 underflow wrap", ccOut, 16'hFFFF);
    clearAndRun(16'h0001, bl);
    sample(16'h7FFF);
    repeat (32800) @(negedge clk);
    check("R1 reach max positive", ccOut, 16'h7FFF);
    sample(16'd1);
    check("R1 overflow wrap", ccOut, 16'h8000);

    // R6 / R7: stop keeps state, resume continues
    clearAndRun(16'h0001, bl);
    wr(2'd1, 16'd4);
    sample(16'd3);
    wr(2'd0, 16'h0000);
    sample(16'd5);
    repeat (3) @(negedge clk);
    check("R6 stopped holds", ccOut, 16'h0);
    check("R6 run bit low", ctrlStat[0], 1'b0);
    wr(2'd0, 16'h0001);
    sample(16'd1);
    check("R7 residue kept on resume", ccOut, 16'd1);

    // R8: offset subtraction
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd2);
    clearAndRun(16'h0001, bl);
    sample(16'd5);
    repeat (5) @(negedge clk);
    check("R8 offset applied", ccOut, 16'd3);

    // R9: correction disabled bypasses offset and dither
    clearAndRun(16'h0019, bl);
    sample(16'd5);
    repeat (6) @(negedge clk);
    check("R9 bypass exact", ccOut, 16'd5);
    for (int k = 0; k < 4; k++) sample(16'd0);
    check("R9 dither muted", ccOut, 16'd5);

    // R10: dither moves count by exactly one per zero sample
    wr(2'd2, 16'd0);
    clearAndRun(16'h0011, bl);
    for (int k = 0; k < 6; k++) begin
      prev = ccOut;
      sample(16'd0);
      check("R10 dither step", ((ccOut - prev) == 16'd1) || ((prev - ccOut) == 16'd1), 1'b1);
    end

    // R11: calibration flag persists, counting continues
    clearAndRun(16'h0005, bl);
    check("R11 flag set", ctrlStat[2], 1'b1);
    sample(16'd2);
    repeat (3) @(negedge clk);
    check("R11 counts during calibration", ccOut, 16'd2);
    check("R11 flag still set", ctrlStat[2], 1'b1);
    wr(2'd0, 16'h0001);
    check("R11 flag cleared by host", ctrlStat[2], 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule